// File: doc/BRIEF.md
# Data-Side Translation Lookaside Buffer with Access Permission Check

This block translates 32-bit virtual data addresses into physical addresses through a small fully associative table of page mappings. Each request carries a virtual address, an access kind (load, store or cache-flush) and the identifier of the running process. The block compares the request against every table slot in parallel. It then returns one of three results: a permitted translation, a permission violation, or a miss. A miss is classed as a fast miss or a double miss, depending on an exception-handler status input.

Software or a refill engine loads the slots through an indexed write port. Each slot holds:
- a virtual page number;
- a process identifier;
- a global flag;
- read and write permission flags;
- a valid flag;
- a physical frame number.

Pages are 4 KB, so the low 12 address bits pass through untranslated.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response channel in the next cycle. A response stays on the channel, unchanged, until the cycle in which `resp_ready` is high. `req_ready` is high whenever the response register is empty or is being drained in that cycle, so back-pressure on the response side stalls new requests.

Top module: `dtlb_lookup`

## Requirements
- R1: A slot matches a request when its valid flag is 1, its page number equals address bits [31:12], and either its global flag is 1 or its process identifier equals `cur_pid`. Slots with the valid flag at 0 never match.
- R2: For a load (`req_kind` 0) that matches, the result is a permitted translation only if the slot's read flag is 1. Otherwise `resp_exc` is 1 (permission violation) and `resp_hit` is 1.
- R3: For a store (`req_kind` 1) that matches, the result is a permitted translation only if the slot's write flag is 1. Otherwise `resp_exc` is 1.
- R4: A cache-flush (`req_kind` 2) that matches is always permitted, whatever the read and write flags are. Kind code 3 is checked exactly like a load.
- R5: On a permitted translation, `resp_exc` is 0, `resp_hit` is 1 and `resp_paddr` is the slot's frame number followed by address bits [11:0]. On any exception, `resp_paddr` is 0.
- R6: When no slot matches, `resp_hit` is 0 and the miss is always reported. `resp_exc` is 2 (fast miss) when `eh_bit` is 0 and 3 (double miss) when `eh_bit` is 1, sampled in the acceptance cycle.
- R7: When several slots match, the slot with the lowest index supplies the result.
- R8: A slot write issued with `wr_en` is visible to requests accepted from the next cycle onward. A request accepted in the same cycle as the write sees the old contents.
- R9: The response appears the cycle after acceptance. `req_ready` equals `!resp_valid || resp_ready`. While `resp_valid` is 1 and `resp_ready` is 0, all response outputs hold steady.
- R10: After reset, every slot is invalid and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_pid | input | 8 | Process identifier to store |
| wr_glob | input | 1 | Global flag to store |
| wr_rd | input | 1 | Read permission to store |
| wr_wr | input | 1 | Write permission to store |
| wr_vld | input | 1 | Valid flag to store |
| wr_pfn | input | 20 | Physical frame number to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 cache-flush, 3 treated as load |
| cur_pid | input | 8 | Running process identifier |
| eh_bit | input | 1 | Exception-handler status bit, selects the miss class |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | A slot matched |
| resp_exc | output | 2 | 0 none, 1 permission violation, 2 fast miss, 3 double miss |
| resp_paddr | output | 32 | Physical address, 0 on exception |

## Verification
The assertions check several rules on every cycle:
- a held response stays unchanged under back-pressure;
- the miss class follows `eh_bit`;
- a load without read permission faults;
- any exception zeroes the address;
- a slot write lands in the indexed slot;
- the chosen slot is the lowest-indexed matching one.

Other behaviour only the bench scenarios can show. The full match rule needs the global flag and process identifier combined with every permission pattern and access kind. A request issued in the same cycle as a write must see the old contents. The frame/offset concatenation must produce the correct address values. The bench checks all of these against its own model of the table.

// File: rtl/dtlb_pkg.sv
`timescale 1ns/1ps
package dtlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FLUSH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    EXC_NONE        = 2'd0,
    EXC_PERM        = 2'd1,
    EXC_FAST_MISS   = 2'd2,
    EXC_DOUBLE_MISS = 2'd3
  } exc_code_e;

  function automatic logic access_allowed(input logic [1:0] kind,
                                          input logic rd, input logic wr);
    case (kind)
      ACC_STORE: return wr;
      ACC_FLUSH: return 1'b1;
      default:   return rd;
    endcase
  endfunction
endpackage

// File: rtl/dtlb_slot_store.sv
`timescale 1ns/1ps
module dtlb_slot_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PID_W-1:0]              wr_pid,
  input  logic                          wr_glob,
  input  logic                          wr_rd,
  input  logic                          wr_wr,
  input  logic                          wr_vld,
  input  logic [PFN_W-1:0]              wr_pfn,
  output logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  output logic [ENTRIES-1:0][PID_W-1:0] pid_q,
  output logic [ENTRIES-1:0][PFN_W-1:0] pfn_q,
  output logic [ENTRIES-1:0]            glob_q,
  output logic [ENTRIES-1:0]            rd_q,
  output logic [ENTRIES-1:0]            wr_q,
  output logic [ENTRIES-1:0]            vld_q
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        vpn_q[e]  <= '0;
        pid_q[e]  <= '0;
        pfn_q[e]  <= '0;
        glob_q[e] <= 1'b0;
        rd_q[e]   <= 1'b0;
        wr_q[e]   <= 1'b0;
      end else if (sel) begin
        vld_q[e]  <= wr_vld;
        vpn_q[e]  <= wr_vpn;
        pid_q[e]  <= wr_pid;
        pfn_q[e]  <= wr_pfn;
        glob_q[e] <= wr_glob;
        rd_q[e]   <= wr_rd;
        wr_q[e]   <= wr_wr;
      end
    end
  end

  // R8: a write lands in the addressed slot on the following cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vpn_q[$past(wr_idx)] == $past(wr_vpn)) &&
              (vld_q[$past(wr_idx)] == $past(wr_vld)));
endmodule

// File: rtl/dtlb_match.sv
`timescale 1ns/1ps
module dtlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_q,
  input  logic [ENTRIES-1:0]            glob_q,
  input  logic [ENTRIES-1:0]            vld_q,
  input  logic [VPN_W-1:0]              look_vpn,
  input  logic [PID_W-1:0]              look_pid,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = vld_q[e] && (vpn_q[e] == look_vpn) &&
                        (glob_q[e] || (pid_q[e] == look_pid));
  end

  always_comb begin
    hit_idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx = IDX_W'(k);
    end
  end

  assign any_hit = |hit_vec;

  // R7: the chosen slot matches and no lower-indexed slot matches
  always_comb begin
    a_r7_lowest_wins: assert (!any_hit ||
      (hit_vec[hit_idx] && ((hit_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));
  end
endmodule

// File: rtl/dtlb_resp.sv
`timescale 1ns/1ps
module dtlb_resp
  import dtlb_pkg::*;
#(
  parameter int PFN_W     = 20,
  parameter int PAGE_BITS = 12,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           kind,
  input  logic                 eh_bit,
  input  logic                 hit_in,
  input  logic                 rd_in,
  input  logic                 wr_in,
  input  logic [PFN_W-1:0]     pfn_in,
  input  logic [PAGE_BITS-1:0] page_off,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic                 resp_hit,
  output logic [1:0]           resp_exc,
  output logic [PA_W-1:0]      resp_paddr
);
  logic      fire;
  logic      allowed;
  exc_code_e exc_nxt;

  assign req_ready = !resp_valid || resp_ready;
  assign fire      = req_valid && req_ready;
  assign allowed   = access_allowed(kind, rd_in, wr_in);

  always_comb begin
    if (!hit_in)      exc_nxt = eh_bit ? EXC_DOUBLE_MISS : EXC_FAST_MISS;
    else if (allowed) exc_nxt = EXC_NONE;
    else              exc_nxt = EXC_PERM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_exc   <= EXC_NONE;
      resp_paddr <= '0;
    end else if (fire) begin
      resp_valid <= 1'b1;
      resp_hit   <= hit_in;
      resp_exc   <= exc_nxt;
      resp_paddr <= (hit_in && allowed) ? {pfn_in, page_off} : '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // R9: stalled response holds
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> resp_valid && $stable(resp_paddr) &&
                                    $stable(resp_exc) && $stable(resp_hit));
  // R6: miss class follows the handler status bit
  a_r6_fast_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit_in && !eh_bit) |=> (resp_exc == 2'd2) && !resp_hit);
  a_r6_double_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit_in && eh_bit) |=> (resp_exc == 2'd3) && !resp_hit);
  // R2: load without read permission faults
  a_r2_load_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_in && (kind == 2'd0) && !rd_in) |=> (resp_exc == 2'd1));
  // R5: exception responses carry a zero address
  a_r5_zero_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_exc != 2'd0)) |-> (resp_paddr == '0));
endmodule

// File: rtl/dtlb_lookup.sv
`timescale 1ns/1ps
module dtlb_lookup #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PID_W     = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_glob,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             wr_vld,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             eh_bit,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_hit,
  output logic [1:0]       resp_exc,
  output logic [PA_W-1:0]  resp_paddr
);
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0]            glob_q, rd_q, wr_q, vld_q;
  logic                          any_hit;
  logic [IDX_W-1:0]              hit_idx;

  dtlb_slot_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_pid(wr_pid), .wr_glob(wr_glob), .wr_rd(wr_rd), .wr_wr(wr_wr),
    .wr_vld(wr_vld), .wr_pfn(wr_pfn), .vpn_q(vpn_q), .pid_q(pid_q),
    .pfn_q(pfn_q), .glob_q(glob_q), .rd_q(rd_q), .wr_q(wr_q), .vld_q(vld_q)
  );

  dtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .vpn_q(vpn_q), .pid_q(pid_q), .glob_q(glob_q), .vld_q(vld_q),
    .look_vpn(req_vaddr[VA_W-1:PAGE_BITS]), .look_pid(cur_pid),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  dtlb_resp #(.PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)) u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .kind(req_kind), .eh_bit(eh_bit), .hit_in(any_hit),
    .rd_in(rd_q[hit_idx]), .wr_in(wr_q[hit_idx]), .pfn_in(pfn_q[hit_idx]),
    .page_off(req_vaddr[PAGE_BITS-1:0]), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_exc(resp_exc),
    .resp_paddr(resp_paddr)
  );
endmodule

// File: tb/sim_dtlb_lookup.sv
`timescale 1ns/1ps
module sim_dtlb_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_pid = '0;
  logic        wr_glob = 1'b0, wr_rd = 1'b0, wr_wr = 1'b0, wr_vld = 1'b0;
  logic [19:0] wr_pfn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  cur_pid = '0;
  logic        eh_bit = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_hit;
  logic [1:0]  resp_exc;
  logic [31:0] resp_paddr;

  int vectors = 0;
  int fails   = 0;

  logic [19:0] m_vpn [16];
  logic [7:0]  m_pid [16];
  logic [19:0] m_pfn [16];
  logic        m_glob[16], m_rd[16], m_wr[16], m_vld[16];

  always #2 clk = ~clk;

  dtlb_lookup u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: returns {hit, exc[1:0], paddr[31:0]}
  function automatic logic [34:0] model(input logic [31:0] va, input logic [1:0] kind,
                                        input logic [7:0] pid, input logic eh);
    for (int j = 0; j < 16; j++) begin
      if (m_vld[j] && m_vpn[j] == va[31:12] && (m_glob[j] || m_pid[j] == pid)) begin
        logic ok;
        ok = (kind == 2'd2) ? 1'b1 : (kind == 2'd1) ? m_wr[j] : m_rd[j];
        return ok ? {1'b1, 2'd0, m_pfn[j], va[11:0]} : {1'b1, 2'd1, 32'd0};
      end
    end
    return {1'b0, (eh ? 2'd3 : 2'd2), 32'd0};
  endfunction

  task automatic write_slot(input int i, input logic [19:0] vpn, input logic [7:0] pid,
                            input logic g, input logic r, input logic w, input logic v,
                            input logic [19:0] pfn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(i); wr_vpn = vpn; wr_pid = pid; wr_glob = g;
    wr_rd = r; wr_wr = w; wr_vld = v; wr_pfn = pfn;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_vpn[i] = vpn; m_pid[i] = pid; m_glob[i] = g; m_rd[i] = r; m_wr[i] = w;
    m_vld[i] = v; m_pfn[i] = pfn;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] kind,
                        input logic [7:0] pid, input logic eh);
    logic [34:0] exp;
    @(negedge clk);
    exp = model(va, kind, pid, eh);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; cur_pid = pid; eh_bit = eh;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {29'd0, resp_valid, resp_hit, resp_exc, resp_paddr}, {29'd0, 1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 1'b0; m_vpn[i] = '0; m_pid[i] = '0; m_pfn[i] = '0;
      m_glob[i] = 1'b0; m_rd[i] = 1'b0; m_wr[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 resp_valid after reset", {63'd0, resp_valid}, 64'd0);
    chk("R10 req_ready after reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    // R10: empty table misses
    lookup("R10 R6 empty table", 32'h1234_5678, 2'd0, 8'h01, 1'b0);

    // fill: read=i[0], write=i[1], global=i[2], slot 15 invalid
    for (int i = 0; i < 16; i++) begin
      logic [3:0] b;
      b = 4'(i);
      write_slot(i, 20'h10000 + 20'(i * 20'h123), 8'(i * 7 + 1), b[2], b[0], b[1],
                 (i != 15), 20'hA0000 ^ 20'(i * 20'h31));
    end

    // sweep: R1 R2 R3 R4 R5, every slot, every kind, own/foreign pid
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] va;
          logic [7:0]  pid;
          va  = {m_vpn[i], 12'(i * 12'h09d + k * 12'h111)};
          pid = p ? (m_pid[i] ^ 8'h55) : m_pid[i];
          lookup("R1 R2 R3 R4 R5 sweep", va, 2'(k), pid, 1'(i));
        end
      end
    end

    // R6: misses of both classes
    for (int k = 0; k < 8; k++) begin
      lookup("R6 miss class", {20'hFFF00 + 20'(k), 12'h3c5}, 2'(k % 4), 8'(k), 1'(k >> 2));
    end

    // R7: two global slots share a page, lowest index wins
    write_slot(3, 20'h5A5A5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 20'h33333);
    write_slot(9, 20'h5A5A5, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 20'h99999);
    lookup("R7 lowest index", 32'h5A5A_5ABC, 2'd0, 8'h77, 1'b0);
    chk("R7 lowest index frame", {32'd0, resp_paddr}, {32'd0, 32'h3333_3ABC});
    write_slot(3, 20'h5A5A5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 20'h33333);
    lookup("R7 R1 invalid slot skipped", 32'h5A5A_5ABC, 2'd0, 8'h77, 1'b0);
    chk("R7 next slot perm fault", {62'd0, resp_exc}, 64'd1);

    // R8: write and request in the same cycle see the old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_vpn = 20'hBEEF0; wr_pid = 8'h11; wr_glob = 1'b1;
    wr_rd = 1'b1; wr_wr = 1'b1; wr_vld = 1'b1; wr_pfn = 20'hCAFE0;
    req_valid = 1'b1; req_vaddr = 32'hBEEF_0123; req_kind = 2'd0; cur_pid = 8'h11; eh_bit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R8 same-cycle old contents", {61'd0, resp_hit, resp_exc}, {61'd0, 1'b0, 2'd3});
    m_vpn[0] = 20'hBEEF0; m_pid[0] = 8'h11; m_glob[0] = 1'b1; m_rd[0] = 1'b1;
    m_wr[0] = 1'b1; m_vld[0] = 1'b1; m_pfn[0] = 20'hCAFE0;
    lookup("R8 next cycle new contents", 32'hBEEF_0123, 2'd1, 8'h22, 1'b1);

    // R9: back-pressure holds the response and stalls requests
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'hBEEF_0FFF; req_kind = 2'd2; cur_pid = 8'h00; eh_bit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 32'h0000_0000;
    chk("R9 response present", {31'd0, resp_valid, resp_paddr}, {31'd0, 1'b1, 32'hCAFE_0FFF});
    chk("R9 req_ready low when stalled", {63'd0, req_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 held under stall", {29'd0, resp_valid, resp_hit, resp_exc, resp_paddr},
        {29'd0, 1'b1, 1'b1, 2'd0, 32'hCAFE_0FFF});
    req_valid = 1'b0;
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", {63'd0, resp_valid}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule